// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Gate

The gate sits behind an instruction buffer and inspects the two oldest decoded instructions every cycle. It decides how many of them enter the parallel pipes in that cycle: none, the oldest alone, or both. Issue always follows program order. The decision depends on three things: whether source registers are still being written by instructions in flight, register dependences between the two candidates, and the limits on how many instructions of each class one group may hold.

The decision is purely combinational. The buffer uses the issue count to shift the remaining entries forward, so an instruction that was held back becomes the oldest candidate in the next cycle. Each candidate is described by a valid bit, a class code, a destination register and two source registers. A destination or source of register 0 means the instruction has no such operand. Class codes are 0 integer, 1 load/store, 2 FP multiply, 3 FP add, 4 branch. Codes 5 to 7 are handled as integer.

Top module: `dual_issue_gate`

## Requirements
- R1: Slot A (the oldest) issues exactly when it is valid and none of its non-zero source registers has its bit set in the busy vector.
- R2: Slot B never issues unless slot A issues in the same cycle.
- R3: Slot B is held when either of its sources equals slot A's non-zero destination.
- R4: Slot B is held when its destination equals slot A's non-zero destination.
- R5: A group never holds two load/store instructions (class 1).
- R6: A group never holds two FP instructions, where classes 2 and 3 both count as FP.
- R7: A branch (class 4) in slot A stops slot B from issuing. A branch in slot B may issue together with slot A.
- R8: Register 0 is never treated as busy and never creates a dependence between the slots, even when busy bit 0 is set.
- R9: The issue count equals the number of issued slots (0, 1 or 2). When nothing blocks slot B, it issues along with slot A and the count is 2.
- R10: Class codes 5 to 7 behave as integer and are subject to no class limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_vld | input | 1 | Slot A holds an instruction |
| a_cls | input | 3 | Slot A class code |
| a_dst | input | REG_W | Slot A destination (0 = none) |
| a_s1 | input | REG_W | Slot A first source (0 = none) |
| a_s2 | input | REG_W | Slot A second source (0 = none) |
| b_vld | input | 1 | Slot B holds an instruction |
| b_cls | input | 3 | Slot B class code |
| b_dst | input | REG_W | Slot B destination (0 = none) |
| b_s1 | input | REG_W | Slot B first source (0 = none) |
| b_s2 | input | REG_W | Slot B second source (0 = none) |
| busy | input | 2**REG_W | Scoreboard: bit r set while register r is pending |
| a_go | output | 1 | Slot A issues this cycle |
| b_go | output | 1 | Slot B issues this cycle |
| go_cnt | output | 2 | Number of instructions issued, used to shift the buffer |

## Verification
All three outputs are combinational, so every result is due in the same cycle as the stimulus, with no register in between. The bench changes inputs on the falling clock edge and compares the outputs against its model a few nanoseconds later, well before the next rising edge. This means every comparison sees settled values for exactly the stimulus just applied. Directed patterns target each hazard and class limit one at a time. A long randomised run then uses a small register range to make collisions frequent.

// File: rtl/dual_issue_gate.sv
module dual_issue_gate #(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input  logic             a_vld,
  input  logic [2:0]       a_cls,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_s1,
  input  logic [REG_W-1:0] a_s2,
  input  logic             b_vld,
  input  logic [2:0]       b_cls,
  input  logic [REG_W-1:0] b_dst,
  input  logic [REG_W-1:0] b_s1,
  input  logic [REG_W-1:0] b_s2,
  input  logic [NREG-1:0]  busy,
  output logic             a_go,
  output logic             b_go,
  output logic [1:0]       go_cnt
);
  localparam logic [2:0] K_MEM  = 3'd1;
  localparam logic [2:0] K_FMUL = 3'd2;
  localparam logic [2:0] K_FADD = 3'd3;
  localparam logic [2:0] K_BR   = 3'd4;

  logic [NREG-1:0] pend;
  assign pend = {busy[NREG-1:1], 1'b0};

  logic a_mem, b_mem, a_fp, b_fp, a_wr;
  assign a_mem = (a_cls == K_MEM);
  assign b_mem = (b_cls == K_MEM);
  assign a_fp  = (a_cls == K_FMUL) || (a_cls == K_FADD);
  assign b_fp  = (b_cls == K_FMUL) || (b_cls == K_FADD);
  assign a_wr  = (a_dst != '0);

  logic b_raw, b_waw, b_struct;
  assign b_raw    = a_wr && ((b_s1 == a_dst) || (b_s2 == a_dst));
  assign b_waw    = a_wr && (b_dst == a_dst);
  assign b_struct = (a_mem && b_mem) || (a_fp && b_fp) || (a_cls == K_BR);

  assign a_go   = a_vld && !pend[a_s1] && !pend[a_s2];
  assign b_go   = a_go && b_vld && !pend[b_s1] && !pend[b_s2]
                  && !b_raw && !b_waw && !b_struct;
  assign go_cnt = {a_go & b_go, a_go ^ b_go};
endmodule

module dual_issue_gate_chk #(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input logic             a_vld,
  input logic [2:0]       a_cls,
  input logic [REG_W-1:0] a_dst,
  input logic [REG_W-1:0] a_s1,
  input logic [2:0]       b_cls,
  input logic [REG_W-1:0] b_dst,
  input logic [REG_W-1:0] b_s1,
  input logic [NREG-1:0]  busy,
  input logic             a_go,
  input logic             b_go,
  input logic [1:0]       go_cnt
);
  always_comb begin
    a_r2_in_order: assert (!(b_go && !a_go));
    a_r1_busy_src: assert (!(a_go && a_s1 != '0 && busy[a_s1]));
    a_r1_invalid:  assert (!(a_go && !a_vld));
    a_r3_raw:      assert (!(b_go && a_dst != '0 && b_s1 == a_dst));
    a_r4_waw:      assert (!(b_go && a_dst != '0 && b_dst == a_dst));
    a_r5_one_mem:  assert (!(b_go && a_cls == 3'd1 && b_cls == 3'd1));
    a_r6_one_fp:   assert (!(b_go && a_cls inside {3'd2, 3'd3} && b_cls inside {3'd2, 3'd3}));
    a_r7_br_last:  assert (!(b_go && a_cls == 3'd4));
    a_r9_count:    assert (go_cnt == 2'(a_go) + 2'(b_go));
  end
endmodule

bind dual_issue_gate dual_issue_gate_chk #(.REG_W(REG_W)) u_chk (
  .a_vld(a_vld), .a_cls(a_cls), .a_dst(a_dst), .a_s1(a_s1),
  .b_cls(b_cls), .b_dst(b_dst), .b_s1(b_s1), .busy(busy),
  .a_go(a_go), .b_go(b_go), .go_cnt(go_cnt)
);

// File: tb/sim_dual_issue_gate.sv
`timescale 1ns/1ps
module sim_dual_issue_gate;
  localparam int RW = 5;
  localparam int NR = 1 << RW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic vld [2];
  logic [2:0] cls [2];
  logic [RW-1:0] dst [2], s1 [2], s2 [2];
  logic [NR-1:0] busy;
  logic a_go, b_go;
  logic [1:0] go_cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dual_issue_gate #(.REG_W(RW)) u0 (
    .a_vld(vld[0]), .a_cls(cls[0]), .a_dst(dst[0]), .a_s1(s1[0]), .a_s2(s2[0]),
    .b_vld(vld[1]), .b_cls(cls[1]), .b_dst(dst[1]), .b_s1(s1[1]), .b_s2(s2[1]),
    .busy(busy), .a_go(a_go), .b_go(b_go), .go_cnt(go_cnt)
  );

  function automatic int expect_n();
    int n = 0, mem = 0, fp = 0;
    bit br = 0;
    for (int k = 0; k < 2; k++) begin
      bit ok = vld[k];
      if (s1[k] != 0 && busy[s1[k]]) ok = 0;
      if (s2[k] != 0 && busy[s2[k]]) ok = 0;
      for (int j = 0; j < k; j++)
        if (dst[j] != 0 && (s1[k] == dst[j] || s2[k] == dst[j] || dst[k] == dst[j])) ok = 0;
      if (cls[k] == 1 && mem > 0) ok = 0;
      if ((cls[k] == 2 || cls[k] == 3) && fp > 0) ok = 0;
      if (br) ok = 0;
      if (!ok) break;
      n++;
      if (cls[k] == 1) mem++;
      if (cls[k] == 2 || cls[k] == 3) fp++;
      if (cls[k] == 4) br = 1;
    end
    return n;
  endfunction

  task automatic slot(int k, logic v, logic [2:0] c, int d, int a, int b);
    vld[k] = v; cls[k] = c; dst[k] = RW'(d); s1[k] = RW'(a); s2[k] = RW'(b);
  endtask

  task automatic check(string tag, int want);
    #4;
    n_chk++;
    if (go_cnt != 2'(want) || a_go != (want >= 1) || b_go != (want == 2)) begin
      n_bad++;
      $display("FAIL %s: got a_go=%0b b_go=%0b cnt=%0d, expected cnt=%0d",
               tag, a_go, b_go, go_cnt, want);
    end
  endtask

  task automatic run(string tag, int want);
    @(negedge clk);
    check(tag, want);
  endtask

  initial begin
    busy = '0; slot(0, 0, 0, 0, 0, 0); slot(1, 0, 0, 0, 0, 0);
    run("R1 R9 idle", 0);
    slot(0, 1, 0, 1, 2, 3); slot(1, 1, 0, 4, 5, 6);
    run("R9 independent pair", 2);
    busy[2] = 1;
    run("R1 R2 slot A source busy", 0);
    busy = '0; busy[6] = 1;
    run("R1 slot B source busy", 1);
    busy = '0; slot(1, 1, 0, 4, 1, 6);
    run("R3 raw on first source", 1);
    slot(1, 1, 0, 4, 5, 1);
    run("R3 raw on second source", 1);
    slot(1, 1, 0, 1, 5, 6);
    run("R4 waw", 1);
    slot(0, 1, 0, 0, 0, 0); slot(1, 1, 0, 0, 0, 0); busy[0] = 1;
    run("R8 register zero", 2);
    busy = '0;
    slot(0, 1, 1, 1, 2, 0); slot(1, 1, 1, 3, 4, 0);
    run("R5 two load/store", 1);
    slot(1, 1, 0, 3, 4, 0);
    run("R5 load/store plus integer", 2);
    slot(0, 1, 2, 1, 2, 0); slot(1, 1, 3, 3, 4, 0);
    run("R6 fmul plus fadd", 1);
    slot(1, 1, 1, 3, 4, 0);
    run("R6 fp plus load/store", 2);
    slot(0, 1, 4, 0, 2, 0); slot(1, 1, 0, 3, 4, 0);
    run("R7 branch in slot A", 1);
    slot(0, 1, 0, 1, 2, 0); slot(1, 1, 4, 0, 4, 0);
    run("R7 branch in slot B", 2);
    slot(0, 0, 0, 1, 2, 0); slot(1, 1, 0, 3, 4, 0);
    run("R2 slot A empty", 0);
    slot(0, 1, 0, 1, 2, 0); slot(1, 0, 0, 3, 4, 0);
    run("R9 slot B empty", 1);
    slot(0, 1, 7, 1, 2, 0); slot(1, 1, 5, 3, 4, 0);
    run("R10 unknown classes", 2);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++)
        slot(k, 1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
             $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4));
      busy = NR'($urandom_range(0, 31)) & NR'($urandom_range(0, 31));
      check("R9 random mix", expect_n());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule